// File: doc/BRIEF.md
# Prefetching Slave Read Port over Four Selectable FIFOs

This block holds four small FIFOs and lets an external master read them through a slave-style strobe interface on a single clock. A 2-bit select picks the FIFO. The master pulls data with an active-low chip select, an active-low output enable and an active-low read strobe. The oldest unread word of the selected FIFO is always presented ahead of time. A master can therefore sample it as soon as the output enable goes low, without first issuing a read.

A read happens only on a rising edge where chip select and the read strobe are both low. Each such edge moves the selected FIFO's read pointer forward by one word. Holding both low streams consecutive words, one per clock.

The output enable does nothing except drive the bus. The bus is modelled as a data-out vector plus a separate drive-enable, so it can be synthesized. A simple fill port loads words into any of the FIFOs. An empty flag and a full flag report the state of the selected FIFOs.

Top module: `slave_fifo_rd`

## Requirements
- R1: After reset every FIFO is empty: `empty` is 1 for every select value, `fill_full` is 0, and no data is presented.
- R2: While the bus is driven and the selected FIFO holds data, `bus_out` equals that FIFO's oldest unread word, with no read strobe needed first.
- R3: `bus_oe` is 1 exactly when `oe_n` and `cs_n` are both 0; output enable alone never moves any read pointer.
- R4: A rising edge with `cs_n`=0, `rd_n`=0 and the selected FIFO not empty consumes one word; the next word is on `bus_out` right after that edge.
- R5: With `cs_n`, `rd_n` and `oe_n` held at 0, each successive rising edge advances exactly one word (N, N+1, N+2, ...).
- R6: When `bus_oe` is 0, `bus_out` is all zeros (the not-driven state).
- R7: `empty` reflects the selected FIFO and changes only as a result of a clock edge. A read attempted while empty is ignored and leaves the pointer unchanged; an empty FIFO presents zeros.
- R8: Each select value addresses an independent FIFO with its own read and write pointers; reading one never alters another.
- R9: `fill_valid`=1 writes `fill_data` into FIFO `fill_sel` on the rising edge unless it already holds DEPTH words. `fill_full` reports that condition for `fill_sel`, and a write while full is dropped.
- R10: `rd_n`=0 with `cs_n`=1 is not a read: no pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_sel | input | AW | FIFO select for the read side |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| rd_n | input | 1 | Active-low read strobe |
| bus_out | output | DW | Data presented on the bus (zero when not driven) |
| bus_oe | output | 1 | Bus drive enable |
| empty | output | 1 | Selected FIFO holds no unread data |
| fill_valid | input | 1 | Write request on the fill port |
| fill_sel | input | AW | FIFO select for the fill port |
| fill_data | input | DW | Word to write |
| fill_full | output | 1 | FIFO at `fill_sel` holds DEPTH words |

## Verification
The bench goes after several faults in turn.

- Output enable advancing the pointer would surface as a skipped word after a stretch of enable-only cycles.
- A design that qualified reads without chip select would lose words while the strobe toggles with the chip deselected.
- Bursts are run through the last word and past empty. An off-by-one in the empty test would show stale data or advance into unwritten slots.
- A FIFO is filled to its limit and one extra write is offered. A dropped full check would corrupt the oldest word.
- Interleaved traffic on different selects shows whether pointers leak between FIFOs.

// File: rtl/slave_fifo_rd.sv
module slave_fifo_rd #(
  parameter int DW    = 16,
  parameter int AW    = 2,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fifo_sel,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          rd_n,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          empty,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_sel,
  input  logic [DW-1:0] fill_data,
  output logic          fill_full
);
  localparam int NB = 1 << AW;
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [DW-1:0] mem [NB][DEPTH];
  logic [PW:0]   rp [NB];
  logic [PW:0]   wp [NB];
  logic [PW:0]   cur_rp;
  logic          rd_fire, wr_fire;

  assign cur_rp    = rp[fifo_sel];
  assign empty     = (cur_rp == wp[fifo_sel]);
  assign fill_full = ((wp[fill_sel] - rp[fill_sel]) == FULL_CNT);
  assign rd_fire   = !cs_n && !rd_n && !empty;
  assign wr_fire   = fill_valid && !fill_full;

  assign bus_oe  = !oe_n && !cs_n;
  assign bus_out = (bus_oe && !empty) ? mem[fifo_sel][cur_rp[PW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        rp[i] <= '0;
        wp[i] <= '0;
      end
    end else begin
      if (rd_fire) rp[fifo_sel] <= cur_rp + 1'b1;
      if (wr_fire) wp[fill_sel] <= wp[fill_sel] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[fill_sel][wp[fill_sel][PW-1:0]] <= fill_data;
  end
endmodule

// File: rtl/slave_fifo_rd_chk.sv
module slave_fifo_rd_chk #(
  parameter int DW = 16,
  parameter int AW = 2,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fifo_sel,
  input logic          cs_n,
  input logic          oe_n,
  input logic          rd_n,
  input logic [DW-1:0] bus_out,
  input logic          bus_oe,
  input logic          empty,
  input logic [PW:0]   cur_rp
);
  // R4 / R5: a valid read moves the selected pointer by exactly one
  a_r4_advance_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && !empty) |=>
      (fifo_sel != $past(fifo_sel)) || (cur_rp == (PW+1)'($past(cur_rp) + 1'b1)));

  // R3 / R10: without a qualified strobe the pointer stays put
  a_r3_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |=>
      (fifo_sel != $past(fifo_sel)) || (cur_rp == $past(cur_rp)));

  // R7: reading an empty FIFO is ignored
  a_r7_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && empty) |=>
      (fifo_sel != $past(fifo_sel)) || (cur_rp == $past(cur_rp)));

  // R6: the undriven bus carries zeros
  a_r6_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0));

  // R3: chip deselected never drives
  a_r3_cs_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !bus_oe);
endmodule

bind slave_fifo_rd slave_fifo_rd_chk #(.DW(DW), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_sel(fifo_sel), .cs_n(cs_n), .oe_n(oe_n),
  .rd_n(rd_n), .bus_out(bus_out), .bus_oe(bus_oe), .empty(empty), .cur_rp(cur_rp)
);

// File: tb/sim_slave_fifo_rd.sv
module sim_slave_fifo_rd;
  localparam int CLK_PER = 10;
  localparam int DW = 16, AW = 2, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] fifo_sel = 0, fill_sel = 0;
  logic cs_n = 1, oe_n = 1, rd_n = 1, fill_valid = 0;
  logic [DW-1:0] fill_data = 0;
  logic [DW-1:0] bus_out;
  logic bus_oe, empty, fill_full;

  int tests = 0, fails = 0;
  logic [DW-1:0] q [4][$];

  always #(CLK_PER/2) clk = ~clk;

  slave_fifo_rd #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_sel(fifo_sel), .cs_n(cs_n), .oe_n(oe_n),
    .rd_n(rd_n), .bus_out(bus_out), .bus_oe(bus_oe), .empty(empty),
    .fill_valid(fill_valid), .fill_sel(fill_sel), .fill_data(fill_data),
    .fill_full(fill_full)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input int sel, input bit cs, input bit rd, input bit oe,
                     input bit fv, input int fs, input int fd);
    bit e_oe, e_empty, rf, wf;
    logic [DW-1:0] e_bus;
    fifo_sel = AW'(sel); cs_n = cs; rd_n = rd; oe_n = oe;
    fill_valid = fv; fill_sel = AW'(fs); fill_data = DW'(fd);
    #1;
    e_oe    = !oe && !cs;
    e_empty = (q[sel].size() == 0);
    e_bus   = (e_oe && !e_empty) ? q[sel][0] : '0;
    chk(tag, "bus_oe", int'(bus_oe), int'(e_oe));
    chk(tag, "empty", int'(empty), int'(e_empty));
    chk(tag, "bus_out", int'(bus_out), int'(e_bus));
    chk(tag, "fill_full", int'(fill_full), int'(q[fs].size() == DEPTH));
    rf = !cs && !rd && !e_empty;
    wf = fv && (q[fs].size() < DEPTH);
    @(posedge clk);
    if (rf) void'(q[sel].pop_front());
    if (wf) q[fs].push_back(DW'(fd));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state on every select
    for (int s = 0; s < 4; s++) cyc("R1", s, 0, 1, 0, 0, s, 0);
    // R9: fill FIFOs
    for (int i = 0; i < 3; i++) cyc("R9", 0, 1, 1, 1, 1, 0, 16'h100 + i);
    for (int i = 0; i < 2; i++) cyc("R9", 1, 1, 1, 1, 1, 1, 16'h200 + i);
    for (int i = 0; i < 5; i++) cyc("R9", 2, 1, 1, 1, 1, 2, 16'h300 + i);
    cyc("R9", 2, 0, 1, 0, 0, 2, 0);
    // R2/R3: enable only, word visible, pointer still
    for (int i = 0; i < 3; i++) cyc("R3", 0, 0, 1, 0, 0, 0, 0);
    cyc("R2", 0, 0, 1, 0, 0, 0, 0);
    // R4: single read
    cyc("R4", 0, 0, 0, 0, 0, 0, 0);
    cyc("R4", 0, 0, 1, 0, 0, 0, 0);
    // R6: enable off
    cyc("R6", 0, 0, 1, 1, 0, 0, 0);
    cyc("R6", 0, 1, 1, 0, 0, 0, 0);
    // R10: strobe without chip select
    for (int i = 0; i < 2; i++) cyc("R10", 0, 1, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 1, 0, 0, 0, 0);
    // R5/R7: burst through empty
    for (int i = 0; i < 4; i++) cyc("R5", 0, 0, 0, 0, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0);
    // R8: other FIFOs untouched
    cyc("R8", 1, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R8", 2, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1, 0, 0, 0, 0, 0, 0);
    cyc("R8", 3, 0, 0, 0, 0, 3, 0);
    // R7/R9: read empty while filling the same FIFO
    cyc("R7", 0, 0, 0, 0, 1, 0, 16'h4aa);
    cyc("R7", 0, 0, 0, 0, 1, 0, 16'h4bb);
    cyc("R7", 0, 0, 1, 0, 0, 0, 0);
    // R8: mixed traffic
    for (int i = 0; i < 200; i++)
      cyc("R8", (i * 7) % 4, (i % 5) == 4, (i % 3) == 0, (i % 4) == 3,
          (i % 2) == 0, (i * 3) % 4, 16'h5000 + i);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule